// File: doc/BRIEF.md
# Program Fetch Region Decoder with Wait States

This block sits between a processor's instruction fetch port and three program-memory regions in a 16-bit (64 KB) code space. The low part of the space, below a parameterised boundary, is on-chip ROM. The high part, from a second parameterised base up to the top address, is on-chip RAM. Everything between the two, and every address when the external-only input is high, goes to off-chip memory.

For each fetch the block picks the region and takes the byte from that region's read bus. It returns the byte together with a one-cycle valid pulse and the region code. On-chip fetches always take the same short fixed time. Off-chip fetches are stretched by a wait count that software can change at run time. A slow device can stretch them further by holding its ready input low.

A separate write port lets a boot loader store bytes into the on-chip RAM. A write that decodes to any other region produces no write strobe.

Top module: `pfr_top`

## Requirements
- R1: After reset, fetch_valid, ext_rd and ram_we are low and the off-chip wait count is 7.
- R2: With ext_only low, an address below ROM_SIZE (default 0x0400) decodes as ROM, region code 0, and the byte comes from rom_rdata.
- R3: With ext_only low, an address at or above RAM_BASE (default 0xF000) decodes as RAM, region code 2, and the byte comes from ram_rdata.
- R4: With ext_only low, an address from ROM_SIZE up to RAM_BASE-1 decodes as off-chip, region code 1, and the byte comes from ext_rdata.
- R5: While ext_only is high, every fetch address decodes as off-chip, region code 1.
- R6: An on-chip fetch whose request is sampled at edge E0 captures the byte at edge E0+1. fetch_valid is high in the cycle after that edge, and ext_rd stays low for the whole fetch.
- R7: With ext_ready high, an off-chip fetch sampled at E0 with wait count N captures the byte at edge E0+N+1. A count of 0 gives the same timing as an on-chip fetch.
- R8: An off-chip fetch ends only at an edge where its countdown has finished and ext_ready is high. ext_rd is high from the cycle after E0 until that edge.
- R9: wait_cfg_val is stored as the wait count at an edge where wait_cfg_we is high. A fetch uses the count it found at its own E0, so a write during a fetch affects only later fetches.
- R10: ram_we pulses in the cycle after pm_wr_req is sampled, with ram_waddr = pm_wr_addr - RAM_BASE and ram_wdata = pm_wr_data. This happens only when the address decodes as RAM with ext_only low. Any other write request leaves ram_we low.
- R11: fetch_valid is high for exactly one cycle per fetch. fetch_data and fetch_region hold their values until the next fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | input | 1 | Fetch request; held, with a stable address, until fetch_valid |
| fetch_addr | input | 16 | Fetch address |
| ext_only | input | 1 | Route all program addresses off-chip |
| wait_cfg_we | input | 1 | Write enable for the wait count |
| wait_cfg_val | input | 3 | New wait count |
| rom_rdata | input | 8 | On-chip ROM read data (one-cycle synchronous read of fetch_addr) |
| ram_rdata | input | 8 | On-chip RAM read data (one-cycle synchronous read of fetch_addr) |
| ext_rdata | input | 8 | Off-chip read data |
| ext_ready | input | 1 | Off-chip device ready; low stretches the fetch |
| pm_wr_req | input | 1 | Program-memory write request |
| pm_wr_addr | input | 16 | Program-memory write address |
| pm_wr_data | input | 8 | Program-memory write data |
| fetch_valid | output | 1 | One-cycle pulse when fetch_data is new |
| fetch_data | output | 8 | Fetched byte |
| fetch_region | output | 2 | Region of the last completed fetch: 0 ROM, 1 off-chip, 2 RAM |
| ext_rd | output | 1 | Off-chip read in progress |
| ram_we | output | 1 | On-chip RAM write strobe |
| ram_waddr | output | 12 | Write offset inside the on-chip RAM |
| ram_wdata | output | 8 | On-chip RAM write data |

## Verification
A wrong region latch or a wrong read-bus selection shows up in the first fetch that completes. The byte and the region code at fetch_valid are then the wrong ones, one or two cycles after the request. A wait counter that loads the wrong value, or that ignores ext_ready, moves the fetch_valid pulse by whole cycles. The bench sees this at the first off-chip fetch because it measures the latency of every fetch exactly. A corrupt write decode appears as a ram_we pulse, or a missing one, in the cycle right after the write request.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  // Region codes, visible on fetch_region.
  typedef enum logic [1:0] {
    RGN_ROM = 2'd0,
    RGN_EXT = 2'd1,
    RGN_RAM = 2'd2
  } region_e;

  // Fetch sequencer states.
  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_ONCHIP = 2'd1,
    FS_EXT    = 2'd2
  } fstate_e;

endpackage

// File: rtl/pfr_region_decode.sv
module pfr_region_decode
  import pfr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ROM_SIZE = 1024,
  parameter int RAM_BASE = 61440
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_only,
  output region_e           region
);

  // One extra bit so that ROM_SIZE or RAM_BASE equal to 2**ADDR_W can
  // express an empty region.
  localparam logic [ADDR_W:0] ROM_LIM  = (ADDR_W+1)'(ROM_SIZE);
  localparam logic [ADDR_W:0] RAM_LIM  = (ADDR_W+1)'(RAM_BASE);

  logic [ADDR_W:0] addr_w;
  assign addr_w = {1'b0, addr};

  always_comb begin
    if (ext_only)                region = RGN_EXT;
    else if (addr_w < ROM_LIM)   region = RGN_ROM;
    else if (addr_w >= RAM_LIM)  region = RGN_RAM;
    else                         region = RGN_EXT;
  end

endmodule

// File: rtl/pfr_wait_counter.sv
module pfr_wait_counter #(
  parameter int WAIT_W   = 3,
  parameter int WAIT_RST = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WAIT_W-1:0] cfg_val,
  input  logic              load,
  input  logic              dec,
  output logic              cnt_zero
);

  localparam logic [WAIT_W-1:0] RST_VAL = WAIT_W'(WAIT_RST);

  logic [WAIT_W-1:0] cfg_q;
  logic [WAIT_W-1:0] cnt_q;

  // Software-visible setting; a write never touches the running count.
  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= RST_VAL;
    else if (cfg_we) cfg_q <= cfg_val;
  end

  // Per-fetch countdown, loaded from the setting at fetch start.
  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= cfg_q;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/pfr_fetch_seq.sv
module pfr_fetch_seq
  import pfr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  region_e           region_now,
  input  logic              cnt_zero,
  input  logic              ext_ready,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              cnt_load,
  output logic              cnt_dec,
  output logic              ext_rd,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output region_e           region_out
);

  fstate_e state_q;
  region_e rgn_q;
  logic    start;
  logic    ext_done;

  assign start    = (state_q == FS_IDLE) && req;
  assign cnt_load = start && (region_now == RGN_EXT);
  assign cnt_dec  = (state_q == FS_EXT) && !cnt_zero;
  assign ext_done = (state_q == FS_EXT) && cnt_zero && ext_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FS_IDLE;
      rgn_q      <= RGN_ROM;
      ext_rd     <= 1'b0;
      valid      <= 1'b0;
      data       <= '0;
      region_out <= RGN_ROM;
    end else begin
      valid <= 1'b0;
      unique case (state_q)
        FS_IDLE: begin
          if (start) begin
            rgn_q <= region_now;
            if (region_now == RGN_EXT) begin
              state_q <= FS_EXT;
              ext_rd  <= 1'b1;
            end else begin
              state_q <= FS_ONCHIP;
            end
          end
        end
        FS_ONCHIP: begin
          // Synchronous on-chip memories have the byte ready one edge
          // after the address was presented.
          data       <= (rgn_q == RGN_RAM) ? ram_rdata : rom_rdata;
          region_out <= rgn_q;
          valid      <= 1'b1;
          state_q    <= FS_IDLE;
        end
        FS_EXT: begin
          if (ext_done) begin
            data       <= ext_rdata;
            region_out <= RGN_EXT;
            valid      <= 1'b1;
            ext_rd     <= 1'b0;
            state_q    <= FS_IDLE;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pfr_pm_write.sv
module pfr_pm_write
  import pfr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RAM_BASE = 61440,
  parameter int RAM_AW   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  region_e           wr_region,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(RAM_BASE);

  logic [ADDR_W-1:0] offset;
  assign offset = wr_addr - BASE_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= wr_req && (wr_region == RGN_RAM);
      if (wr_req) begin
        ram_waddr <= offset[RAM_AW-1:0];
        ram_wdata <= wr_data;
      end
    end
  end

endmodule

// File: rtl/pfr_top.sv
module pfr_top
  import pfr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int WAIT_W   = 3,
  parameter int WAIT_RST = 7,
  parameter int ROM_SIZE = 1024,
  parameter int RAM_BASE = 61440,
  parameter int RAM_AW   = $clog2((2 ** ADDR_W) - RAM_BASE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              ext_only,
  input  logic              wait_cfg_we,
  input  logic [WAIT_W-1:0] wait_cfg_val,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_ready,
  input  logic              pm_wr_req,
  input  logic [ADDR_W-1:0] pm_wr_addr,
  input  logic [DATA_W-1:0] pm_wr_data,
  output logic              fetch_valid,
  output logic [DATA_W-1:0] fetch_data,
  output logic [1:0]        fetch_region,
  output logic              ext_rd,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata
);

  region_e fetch_rgn;
  region_e write_rgn;
  region_e rgn_out;
  logic    cnt_load;
  logic    cnt_dec;
  logic    cnt_zero;

  pfr_region_decode #(
    .ADDR_W(ADDR_W), .ROM_SIZE(ROM_SIZE), .RAM_BASE(RAM_BASE)
  ) u_dec_fetch (
    .addr(fetch_addr), .ext_only(ext_only), .region(fetch_rgn)
  );

  pfr_region_decode #(
    .ADDR_W(ADDR_W), .ROM_SIZE(ROM_SIZE), .RAM_BASE(RAM_BASE)
  ) u_dec_write (
    .addr(pm_wr_addr), .ext_only(ext_only), .region(write_rgn)
  );

  pfr_wait_counter #(
    .WAIT_W(WAIT_W), .WAIT_RST(WAIT_RST)
  ) u_wait (
    .clk(clk), .rst(rst),
    .cfg_we(wait_cfg_we), .cfg_val(wait_cfg_val),
    .load(cnt_load), .dec(cnt_dec), .cnt_zero(cnt_zero)
  );

  pfr_fetch_seq #(
    .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req(fetch_req), .region_now(fetch_rgn),
    .cnt_zero(cnt_zero), .ext_ready(ext_ready),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .ext_rdata(ext_rdata),
    .cnt_load(cnt_load), .cnt_dec(cnt_dec),
    .ext_rd(ext_rd), .valid(fetch_valid),
    .data(fetch_data), .region_out(rgn_out)
  );

  assign fetch_region = rgn_out;

  pfr_pm_write #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BASE(RAM_BASE), .RAM_AW(RAM_AW)
  ) u_wr (
    .clk(clk), .rst(rst),
    .wr_req(pm_wr_req), .wr_addr(pm_wr_addr), .wr_data(pm_wr_data),
    .wr_region(write_rgn),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int ADDR_W   = 16,
  parameter int RAM_BASE = 61440
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic              ext_only,
  input logic              ext_ready,
  input logic              pm_wr_req,
  input logic [ADDR_W-1:0] pm_wr_addr,
  input logic              fetch_valid,
  input logic [1:0]        fetch_region,
  input logic              ext_rd,
  input logic              ram_we
);

  localparam logic [ADDR_W:0] RAM_LIM = (ADDR_W+1)'(RAM_BASE);

  p_valid_single_r11: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> !fetch_valid);

  p_ext_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_region == 2'd1) |-> $past(ext_ready));

  p_ext_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ext_rd && !ext_ready) |=> ext_rd);

  p_onchip_no_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_region != 2'd1) |-> !$past(ext_rd));

  p_valid_had_req_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> $past(fetch_req));

  p_ram_we_source_r10: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(pm_wr_req) && !$past(ext_only)
                && ({1'b0, $past(pm_wr_addr)} >= RAM_LIM)));

  p_region_code_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_region != 2'd3);

endmodule

bind pfr_top pfr_checker #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)) u_chk (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .ext_only(ext_only),
  .ext_ready(ext_ready), .pm_wr_req(pm_wr_req), .pm_wr_addr(pm_wr_addr),
  .fetch_valid(fetch_valid), .fetch_region(fetch_region), .ext_rd(ext_rd),
  .ram_we(ram_we)
);

// File: tb/pfr_top_test.sv
module pfr_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        ext_only = 1'b0;
  logic        wait_cfg_we = 1'b0;
  logic [2:0]  wait_cfg_val = '0;
  logic [7:0]  rom_rdata = '0;
  logic [7:0]  ram_rdata = '0;
  logic [7:0]  ext_rdata;
  logic        ext_ready;
  logic        pm_wr_req = 1'b0;
  logic [15:0] pm_wr_addr = '0;
  logic [7:0]  pm_wr_data = '0;
  logic        fetch_valid;
  logic [7:0]  fetch_data;
  logic [1:0]  fetch_region;
  logic        ext_rd;
  logic        ram_we;
  logic [11:0] ram_waddr;
  logic [7:0]  ram_wdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int hold_cycles = 0;
  int ext_cnt = 0;

  typedef struct {
    logic [7:0] data;
    logic [1:0] region;
    int         lat;
    int         start;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  pfr_top uut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .ext_only(ext_only), .wait_cfg_we(wait_cfg_we), .wait_cfg_val(wait_cfg_val),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .ext_rdata(ext_rdata),
    .ext_ready(ext_ready), .pm_wr_req(pm_wr_req), .pm_wr_addr(pm_wr_addr),
    .pm_wr_data(pm_wr_data), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fetch_region(fetch_region), .ext_rd(ext_rd), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory models: on-chip buses read synchronously, off-chip combinationally.
  function automatic logic [7:0] rom_f(logic [15:0] a); return a[7:0] ^ 8'h3C; endfunction
  function automatic logic [7:0] ram_f(logic [15:0] a); return a[7:0] ^ a[15:8] ^ 8'hC3; endfunction
  function automatic logic [7:0] ext_f(logic [15:0] a); return a[7:0] + a[15:8] + 8'h11; endfunction

  always @(posedge clk) begin
    cyc       <= cyc + 1;
    rom_rdata <= rom_f(fetch_addr);
    ram_rdata <= ram_f(fetch_addr);
    ext_cnt   <= ext_rd ? ext_cnt + 1 : 0;
  end
  assign ext_rdata = ext_f(fetch_addr);
  assign ext_ready = (ext_cnt >= hold_cycles);

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor: pop the expected item as each fetch completes.
  always @(negedge clk) begin
    if (!rst && fetch_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected fetch_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(fetch_data == e.data, e.tag, "data", fetch_data, e.data);
        check(fetch_region == e.region, e.tag, "region", fetch_region, e.region);
        check(cyc - e.start == e.lat, e.tag, "latency", cyc - e.start, e.lat);
      end
    end
  end

  task automatic set_wait(logic [2:0] w);
    @(negedge clk);
    wait_cfg_we = 1'b1; wait_cfg_val = w;
    @(negedge clk);
    wait_cfg_we = 1'b0;
  endtask

  // Driver: cur_wait is the count in force at fetch start; new_wait >= 0
  // writes the setting in the same cycle the fetch starts.
  task automatic do_fetch(logic [15:0] a, bit xo, int cur_wait, int hold,
                          int new_wait, string tag);
    exp_t e;
    bit   onchip;
    bit   saw_ext;
    bit   done;
    @(negedge clk);
    ext_only    = xo;
    fetch_addr  = a;
    hold_cycles = hold;
    fetch_req   = 1'b1;
    if (new_wait >= 0) begin
      wait_cfg_we = 1'b1; wait_cfg_val = 3'(new_wait);
    end
    onchip = !xo && (a < 16'h0400 || a >= 16'hF000);
    if (onchip) begin
      e.region = (a < 16'h0400) ? 2'd0 : 2'd2;
      e.data   = (a < 16'h0400) ? rom_f(a) : ram_f(a);
      e.lat    = 2;
    end else begin
      e.region = 2'd1;
      e.data   = ext_f(a);
      e.lat    = ((cur_wait > hold) ? cur_wait : hold) + 2;
    end
    e.start = cyc;
    e.tag   = tag;
    exp_q.push_back(e);
    saw_ext = 1'b0;
    done    = 1'b0;
    for (int i = 0; i < 40 && !done; i++) begin
      @(negedge clk);
      wait_cfg_we = 1'b0;
      if (ext_rd) saw_ext = 1'b1;
      if (fetch_valid) done = 1'b1;
    end
    fetch_req = 1'b0;
    if (!done) check(1'b0, tag, "fetch timeout", 0, 1);
    if (onchip) check(!saw_ext, "R6", "ext_rd during on-chip fetch", saw_ext, 0);
    else        check(saw_ext, "R8", "ext_rd during off-chip fetch", saw_ext, 1);
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d, bit xo, bit expect_we);
    @(negedge clk);
    ext_only = xo; pm_wr_req = 1'b1; pm_wr_addr = a; pm_wr_data = d;
    @(negedge clk);
    pm_wr_req = 1'b0;
    check(ram_we == expect_we, "R10", "ram_we", ram_we, expect_we);
    if (expect_we) begin
      check(ram_waddr == 12'(a - 16'hF000), "R10", "ram_waddr", ram_waddr, 12'(a - 16'hF000));
      check(ram_wdata == d, "R10", "ram_wdata", ram_wdata, d);
    end
    @(negedge clk);
    check(ram_we == 1'b0, "R10", "ram_we one cycle", ram_we, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", "run expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held_d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(fetch_valid == 1'b0, "R1", "fetch_valid after reset", fetch_valid, 0);
    check(ext_rd == 1'b0, "R1", "ext_rd after reset", ext_rd, 0);
    check(ram_we == 1'b0, "R1", "ram_we after reset", ram_we, 0);

    // R2 ROM region, including both ends
    do_fetch(16'h0000, 1'b0, 7, 0, -1, "R2");
    do_fetch(16'h03FF, 1'b0, 7, 0, -1, "R2");
    // R1 / R4: off-chip with the reset wait count of 7
    do_fetch(16'h0400, 1'b0, 7, 0, -1, "R1");
    // R11: outputs hold after the pulse
    held_d = fetch_data;
    @(negedge clk);
    check(fetch_valid == 1'b0, "R11", "valid single pulse", fetch_valid, 0);
    check(fetch_data == held_d, "R11", "data held", fetch_data, held_d);
    check(fetch_region == 2'd1, "R11", "region held", fetch_region, 1);

    set_wait(3'd2);
    do_fetch(16'h1234, 1'b0, 2, 0, -1, "R7");
    do_fetch(16'hEFFF, 1'b0, 2, 0, -1, "R4");
    // R8 ready low beyond the countdown
    do_fetch(16'h2345, 1'b0, 2, 5, -1, "R8");
    // R3 RAM region
    do_fetch(16'hF000, 1'b0, 2, 0, -1, "R3");
    do_fetch(16'hFFFF, 1'b0, 2, 0, -1, "R3");
    // R5 external-only
    do_fetch(16'h0010, 1'b1, 2, 0, -1, "R5");
    do_fetch(16'hF800, 1'b1, 2, 0, -1, "R5");
    // R7 zero waits equals on-chip timing
    set_wait(3'd0);
    do_fetch(16'h5000, 1'b0, 0, 0, -1, "R7");
    // R9 change during a fetch takes effect only on the next one
    do_fetch(16'h6000, 1'b0, 0, 0, 3, "R9");
    do_fetch(16'h6001, 1'b0, 3, 0, -1, "R9");
    // R8 countdown longer than the stall
    do_fetch(16'h7000, 1'b0, 3, 1, -1, "R8");
    // back-to-back on-chip (R6)
    do_fetch(16'h0100, 1'b0, 3, 0, -1, "R6");
    do_fetch(16'hF123, 1'b0, 3, 0, -1, "R6");

    // R10 write strobe
    do_write(16'hF010, 8'hA5, 1'b0, 1'b1);
    do_write(16'hFFFF, 8'h5A, 1'b0, 1'b1);
    do_write(16'h0010, 8'h77, 1'b0, 1'b0);
    do_write(16'h8000, 8'h66, 1'b0, 1'b0);
    do_write(16'hF020, 8'h55, 1'b1, 1'b0);
    ext_only = 1'b0;

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11", "pending fetches", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule